// File: doc/BRIEF.md
# Round Key Store for a Folded Block Cipher Core

This block holds a precomputed AES expanded key next to a folded cipher datapath, so that the datapath never waits on main memory for its round keys. Software computes the expansion. It then streams the expansion into the block as a run of 64-bit bus words, starting with round key 0. While blocks are being ciphered, the datapath reads the key for the round it is currently computing through a 128-bit indexed port.

The round keys used by the prologue (round 0) and the epilogue (round Nr) are held in two dedicated registers that are always visible. All rounds in between are kept in four 32-bit-wide memory lanes. The lanes are read in parallel with one cycle of latency. Because of this split, the initial key, the final key and one indexed key can all be used in the same cycle.

The number of rounds is captured together with the load-start strobe. Stored contents survive between operations, so a key loaded once serves any number of later blocks. The depth is set by a parameter and defaults to 14 rounds (1920 bits).

Top module: `rkey_store`

## Requirements
- R1: After reset, `first_key`, `last_key` and `rd_key` are all zero.
- R2: Bus words are numbered from 0 upward, and `load_start` restarts the numbering. A word written in the same cycle as `load_start` is word 0. Word k belongs to round key k/2. An even k fills key bits [127:64] and an odd k fills bits [63:0].
- R3: Words of round 0 are written only to `first_key`. The new value is visible from the clock edge that accepts the word.
- R4: Words of round Nr are written only to `last_key`. Nr is the value of `cfg_rounds` sampled in the `load_start` cycle and is expected to lie between 1 and `MAX_ROUNDS`.
- R5: Words of rounds 1 to Nr-1 go to the lane memories. Lane n holds key bits [32n+31:32n]. Setting `rd_round` to r returns that stored key on `rd_key` one clock edge later.
- R6: A `rd_round` of 0, or of `MAX_ROUNDS` or above, returns all zeros on `rd_key` one edge later.
- R7: Once all 2·(Nr+1) words of a load have been accepted, further words are ignored until the next `load_start`. This holds for the registers and for the memory lanes.
- R8: A `load_start` with no words that follow leaves every stored key unchanged and readable.
- R9: A read and a write to the same memory entry in the same cycle return the entry as it was before that write.
- R10: `first_key` and `last_key` do not change in any cycle without `wr_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_start | input | 1 | Restarts word numbering and samples `cfg_rounds` |
| cfg_rounds | input | RW (4) | Number of cipher rounds Nr for the new load |
| wr_vld | input | 1 | `wr_data` carries the next expansion word |
| wr_data | input | BUS_W (64) | Expansion word |
| rd_round | input | RW (4) | Round index for the indexed read |
| rd_key | output | RK_W (128) | Indexed round key, one cycle after `rd_round` |
| first_key | output | RK_W (128) | Round 0 key |
| last_key | output | RK_W (128) | Round Nr key |

## Verification
Two collisions are provoked on purpose. In the first, the opening word of a new load is driven in the same cycle as `load_start`. It must land in the upper half of `first_key` and not at the position the old count pointed to. In the second, an indexed read is issued while the lower half of that same round entry is being overwritten. The bench expects a mix: the new upper half, which was written one cycle earlier, and the old lower half from the previous load. A third check writes words after a load is complete and confirms through the read port that an entry left over from an older, longer load is untouched.

// File: rtl/rkey_store.sv
module rkey_store #(
  parameter int MAX_ROUNDS = 14,
  parameter int BUS_W      = 64,
  parameter int RK_W       = 128,
  localparam int RW        = $clog2(MAX_ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic [RW-1:0]    cfg_rounds,
  input  logic             wr_vld,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [RW-1:0]    rd_round,
  output logic [RK_W-1:0]  rd_key,
  output logic [RK_W-1:0]  first_key,
  output logic [RK_W-1:0]  last_key
);
  localparam int WPK    = RK_W / BUS_W;
  localparam int LANES  = RK_W / 32;
  localparam int LPW    = BUS_W / 32;
  localparam int DEPTH  = MAX_ROUNDS - 1;
  localparam int NWORDS = WPK * (MAX_ROUNDS + 1);
  localparam int CW     = $clog2(NWORDS + 1);
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0]   cnt_q, widx, wround, wpart;
  logic [RW-1:0]   nr_q, nr_now;
  logic            take, to_first, to_last, to_mem;
  logic [AW-1:0]   waddr, raddr;
  logic            rd_ok, rd_ok_q;
  logic [RK_W-1:0] first_q, last_q, rd_word;

  assign widx     = load_start ? '0 : cnt_q;
  assign nr_now   = load_start ? cfg_rounds : nr_q;
  assign wround   = widx / CW'(WPK);
  assign wpart    = widx % CW'(WPK);
  assign take     = wr_vld && (wround <= CW'(nr_now));
  assign to_first = take && (wround == '0);
  assign to_last  = take && !to_first && (wround == CW'(nr_now));
  assign to_mem   = take && !to_first && !to_last;
  assign waddr    = to_mem ? AW'(wround - 1'b1) : '0;

  assign rd_ok = (rd_round != '0) && (rd_round < RW'(MAX_ROUNDS));
  assign raddr = rd_ok ? AW'(rd_round - 1'b1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      nr_q    <= RW'(MAX_ROUNDS);
      rd_ok_q <= 1'b0;
    end else begin
      nr_q    <= nr_now;
      cnt_q   <= take ? widx + 1'b1 : widx;
      rd_ok_q <= rd_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
    end else begin
      for (int h = 0; h < WPK; h++) begin
        if (to_first && wpart == CW'(h)) first_q[RK_W-1-h*BUS_W -: BUS_W] <= wr_data;
        if (to_last  && wpart == CW'(h)) last_q[RK_W-1-h*BUS_W -: BUS_W]  <= wr_data;
      end
    end
  end

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    localparam int H   = (LANES - 1 - L) / LPW;
    localparam int SUB = L - (LANES - (H + 1) * LPW);
    logic [31:0] mem [DEPTH];
    logic [31:0] q;
    always_ff @(posedge clk) begin
      if (to_mem && wpart == CW'(H)) mem[waddr] <= wr_data[32*SUB +: 32];
      q <= mem[raddr];
    end
    assign rd_word[32*L +: 32] = q;
  end

  assign rd_key    = rd_ok_q ? rd_word : '0;
  assign first_key = first_q;
  assign last_key  = last_q;
endmodule

module rkey_store_chk #(
  parameter int MAX_ROUNDS = 14,
  parameter int BUS_W      = 64,
  parameter int RK_W       = 128,
  localparam int RW        = $clog2(MAX_ROUNDS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_start,
  input logic             wr_vld,
  input logic [BUS_W-1:0] wr_data,
  input logic [RW-1:0]    rd_round,
  input logic [RK_W-1:0]  rd_key,
  input logic [RK_W-1:0]  first_key,
  input logic [RK_W-1:0]  last_key
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_zero_R1: assert (rd_key == '0 && first_key == '0 && last_key == '0)
        else $error("outputs not zero in reset");
    end
  end

  assert_start_word_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && load_start) |=> first_key[RK_W-1 -: BUS_W] == $past(wr_data));

  assert_range_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_round == '0 || rd_round >= RW'(MAX_ROUNDS)) |=> rd_key == '0);

  assert_hold_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vld |=> ($stable(first_key) && $stable(last_key)));
endmodule

bind rkey_store rkey_store_chk #(.MAX_ROUNDS(MAX_ROUNDS), .BUS_W(BUS_W), .RK_W(RK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .load_start(load_start), .wr_vld(wr_vld), .wr_data(wr_data),
  .rd_round(rd_round), .rd_key(rd_key), .first_key(first_key), .last_key(last_key));

// File: tb/rkey_store_tb.sv
module rkey_store_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_start = 1'b0;
  logic [3:0]   cfg_rounds = '0;
  logic         wr_vld = 1'b0;
  logic [63:0]  wr_data = '0;
  logic [3:0]   rd_round = '0;
  logic [127:0] rd_key, first_key, last_key;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rkey_store dut_i (.clk(clk), .rst_n(rst_n), .load_start(load_start), .cfg_rounds(cfg_rounds),
    .wr_vld(wr_vld), .wr_data(wr_data), .rd_round(rd_round), .rd_key(rd_key),
    .first_key(first_key), .last_key(last_key));

  function automatic logic [127:0] kf(int r, int s);
    return {32'(s * 32'h0100_0193 + r), 32'(32'hA5A5_0000 ^ (r * 7) ^ s),
            32'((r + 1) * 32'h9E37_79B9 ^ s), 32'(32'hC3C3_0000 + s * 16 + r)};
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(int r, output logic [127:0] v);
    rd_round = 4'(r);
    @(negedge clk);
    v = rd_key;
  endtask

  // probe_k >= 0: read round probe_r in the same cycle as word probe_k
  task automatic load(int nr, int s, bit start_with_word, int extra, int probe_k, int probe_r,
                      output logic [127:0] probe_v);
    probe_v = '0;
    if (!start_with_word) begin
      load_start = 1; cfg_rounds = 4'(nr);
      @(negedge clk);
      load_start = 0;
    end
    for (int k = 0; k < 2 * (nr + 1) + extra; k++) begin
      logic [127:0] key;
      key = kf(k / 2, s + ((k >= 2 * (nr + 1)) ? 77 : 0));
      wr_vld = 1;
      wr_data = (k % 2 == 0) ? key[127:64] : key[63:0];
      load_start = (start_with_word && k == 0);
      cfg_rounds = 4'(nr);
      if (k == probe_k) rd_round = 4'(probe_r);
      @(negedge clk);
      if (k == probe_k) probe_v = rd_key;
    end
    wr_vld = 0; load_start = 0;
  endtask

  task automatic check_load(int nr, int s, string tag);
    logic [127:0] v;
    chk({tag, " R3 first"}, first_key, kf(0, s));
    chk({tag, " R4 last"}, last_key, kf(nr, s));
    for (int r = 1; r < nr; r++) begin
      rd(r, v);
      chk({tag, " R5 R2 indexed"}, v, kf(r, s));
    end
  endtask

  task automatic t_reset();
    chk("R1 rd_key", rd_key, '0);
    chk("R1 first_key", first_key, '0);
    chk("R1 last_key", last_key, '0);
  endtask

  task automatic t_full_load();
    logic [127:0] p;
    load(14, 1, 0, 0, -1, 0, p);
    check_load(14, 1, "nr14");
  endtask

  task automatic t_start_with_word_and_extra();
    logic [127:0] p, v;
    load(10, 2, 1, 4, -1, 0, p);
    check_load(10, 2, "nr10 coincident R2");
    chk("R7 last after extra", last_key, kf(10, 2));
    chk("R7 first after extra", first_key, kf(0, 2));
    rd(11, v); chk("R7 lane entry 11 kept", v, kf(11, 1));
    rd(12, v); chk("R7 lane entry 12 kept", v, kf(12, 1));
  endtask

  task automatic t_persist();
    logic [127:0] v;
    load_start = 1; cfg_rounds = 4'd6;
    @(negedge clk);
    load_start = 0;
    repeat (3) @(negedge clk);
    chk("R8 first kept", first_key, kf(0, 2));
    chk("R8 last kept", last_key, kf(10, 2));
    rd(5, v); chk("R8 indexed kept", v, kf(5, 2));
    chk("R10 first steady", first_key, kf(0, 2));
  endtask

  task automatic t_range();
    logic [127:0] v;
    rd(0, v);  chk("R6 index 0", v, '0);
    rd(14, v); chk("R6 index 14", v, '0);
    rd(15, v); chk("R6 index 15", v, '0);
    rd(13, v); chk("R5 index 13 from nr14 load", v, kf(13, 1));
  endtask

  task automatic t_read_during_write();
    logic [127:0] p, v;
    load(12, 3, 0, 0, 3, 1, p);
    chk("R9 same-entry read", p, {kf(1, 3)[127:64], kf(1, 2)[63:0]});
    rd(1, v); chk("R9 entry after write", v, kf(1, 3));
    check_load(12, 3, "nr12");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_full_load();
    t_start_with_word_and_extra();
    t_persist();
    t_range();
    t_read_during_write();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule